// File: doc/BRIEF.md
# Fuse Strobe Timing Sequencer

This block times a single access to a one-time-programmable fuse array. A start pulse and an operation select (sense or program) launch a sequence that is timed entirely from cycle counts taken from a packed timing word: a relax count and two strobe counts, one for sensing and one for programming. Software works out those counts from the clock frequency and writes them into the timing word; the sequencer counts cycles only.

The strobe count of each operation covers the whole strobe window, and that window already includes two relax intervals. The sequencer therefore splits the window into a leading relax phase, an active phase with the strobe asserted, and a trailing relax phase. A one-cycle done pulse follows. During a sense operation the fuse data presented on the sense input is captured on the last active cycle and held on the read-data output. The timing word and the operation are latched when a start is accepted, and further starts are ignored until the sequence has ended.

Top module: `fuse_strobe_seq`

## Requirements
- R1: While reset is asserted and until the first accepted start, strobe_o, relax_o, done_o and busy_o are low and rdata_o is zero.
- R2: Timing word fields: relax count in bits 15:12, sense strobe count in bits 21:16, program strobe count in bits 11:0; op_prog_i = 1 selects program (bits 11:0), op_prog_i = 0 selects sense (bits 21:16); the unselected strobe field has no effect.
- R3: After an accepted start, the cycle that follows begins a leading relax phase (relax_o high), then an active phase (strobe_o high), then a trailing relax phase (relax_o high), then exactly one cycle with done_o high; at most one of strobe_o, relax_o, done_o is high in any cycle.
- R4: Each relax phase lasts (relax count + 1) cycles.
- R5: With strobe count C and relax count X, the active phase lasts (C + 1) - 2(X + 1) cycles when that value is at least 1.
- R6: When (C + 1) is at most 2(X + 1), the active phase lasts exactly one cycle.
- R7: For a sense operation, rdata_o takes the value sense_data_i held during the last active cycle, from the cycle after it, and keeps it until the next sense operation captures.
- R8: A program operation leaves rdata_o unchanged.
- R9: busy_o is high from the cycle after an accepted start through the done cycle, and a start is accepted only when busy_o is low; a start while busy_o is high, including during the done cycle, has no effect.
- R10: Changes to timing_i or op_prog_i after an accepted start do not alter the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request to begin one access, sampled while idle |
| op_prog_i | input | 1 | 1 = program, 0 = sense |
| timing_i | input | 22 | Packed relax and strobe counts (stored minus one) |
| sense_data_i | input | 32 | Data sensed from the fuse cell |
| strobe_o | output | 1 | Fuse strobe, high in the active phase |
| relax_o | output | 1 | High in either relax phase |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse ending the sequence |
| rdata_o | output | 32 | Captured sense data |

## Verification
The hardest situation to reach from the ports is a start that arrives during the done cycle, one clock before the sequencer would accept it again; the bench holds start_i high through every whole sequence so that this case and every mid-sequence start occur on each vector, and confirms that busy_o stays low afterwards. The capture point is pinned down by changing sense_data_i every cycle to a value that encodes the cycle number, so a capture one cycle early or late yields a different word. The clamp boundary is approached from both sides, with a strobe count exactly one above twice the relax length and with counts equal to and below it, and the timing word is inverted right after every start to expose any late use of it.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_PRE  = 3'd1,
    PH_ACT  = 3'd2,
    PH_POST = 3'd3,
    PH_DONE = 3'd4
  } phase_e;

endpackage

// File: rtl/fuse_rst_sync.sv
module fuse_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/fuse_len_calc.sv
module fuse_len_calc #(
  parameter int RD_W  = 6,
  parameter int RLX_W = 4,
  parameter int PG_W  = 12,
  parameter int CW    = 14
) (
  input  logic             op_prog,
  input  logic [RD_W-1:0]  rd_cnt,
  input  logic [RLX_W-1:0] rlx_cnt,
  input  logic [PG_W-1:0]  pg_cnt,
  output logic [CW-1:0]    act_m1
);

  logic [CW-1:0] win_len;
  logic [CW-1:0] two_rlx;

  always_comb begin
    if (op_prog) win_len = CW'(pg_cnt) + CW'(1);
    else         win_len = CW'(rd_cnt) + CW'(1);
    two_rlx = (CW'(rlx_cnt) + CW'(1)) << 1;
    if (win_len > two_rlx) act_m1 = win_len - two_rlx - CW'(1);
    else                   act_m1 = '0;
  end

endmodule

// File: rtl/fuse_phase_ctr.sv
module fuse_phase_ctr #(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                    cnt_d = load_val;
    else if (en && cnt_q != '0)  cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == '0);

endmodule

// File: rtl/fuse_strobe_seq.sv
module fuse_strobe_seq
  import fuse_seq_pkg::*;
#(
  parameter int RD_W  = 6,
  parameter int RLX_W = 4,
  parameter int PG_W  = 12,
  parameter int DW    = 32,
  localparam int PG_LSB  = 0,
  localparam int RLX_LSB = PG_LSB + PG_W,
  localparam int RD_LSB  = RLX_LSB + RLX_W,
  localparam int TW      = RD_LSB + RD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          op_prog_i,
  input  logic [TW-1:0] timing_i,
  input  logic [DW-1:0] sense_data_i,
  output logic          strobe_o,
  output logic          relax_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o
);

  localparam int MAXW = (PG_W > RD_W) ? PG_W : RD_W;
  localparam int CW   = ((MAXW > RLX_W) ? MAXW : RLX_W) + 2;

  logic          rst_int_n;
  phase_e        phase_q;
  phase_e        phase_d;
  logic [TW-1:0] tmg_q;
  logic          op_q;
  logic          accept;
  logic          ctr_load;
  logic [CW-1:0] ctr_val;
  logic          ctr_last;
  logic [CW-1:0] act_m1;
  logic          cap_en;
  logic [DW-1:0] rdata_q;

  fuse_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign accept = start_i && (phase_q == PH_IDLE);

  // Timing word and operation held for the whole access
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      tmg_q <= '0;
      op_q  <= 1'b0;
    end else if (accept) begin
      tmg_q <= timing_i;
      op_q  <= op_prog_i;
    end
  end

  fuse_len_calc #(
    .RD_W(RD_W), .RLX_W(RLX_W), .PG_W(PG_W), .CW(CW)
  ) u_len (
    .op_prog (op_q),
    .rd_cnt  (tmg_q[RD_LSB +: RD_W]),
    .rlx_cnt (tmg_q[RLX_LSB +: RLX_W]),
    .pg_cnt  (tmg_q[PG_LSB +: PG_W]),
    .act_m1  (act_m1)
  );

  // Next-phase and counter-load logic
  always_comb begin
    phase_d  = phase_q;
    ctr_load = 1'b0;
    ctr_val  = '0;
    cap_en   = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (accept) begin
          phase_d  = PH_PRE;
          ctr_load = 1'b1;
          ctr_val  = CW'(timing_i[RLX_LSB +: RLX_W]);
        end
      end
      PH_PRE: begin
        if (ctr_last) begin
          phase_d  = PH_ACT;
          ctr_load = 1'b1;
          ctr_val  = act_m1;
        end
      end
      PH_ACT: begin
        if (ctr_last) begin
          phase_d  = PH_POST;
          ctr_load = 1'b1;
          ctr_val  = CW'(tmg_q[RLX_LSB +: RLX_W]);
          cap_en   = !op_q;
        end
      end
      PH_POST: begin
        if (ctr_last) phase_d = PH_DONE;
      end
      PH_DONE: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) phase_q <= PH_IDLE;
    else            phase_q <= phase_d;
  end

  fuse_phase_ctr #(.CW(CW)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .en       (phase_q != PH_IDLE),
    .load     (ctr_load),
    .load_val (ctr_val),
    .last_o   (ctr_last)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rdata_q <= '0;
    else if (cap_en) rdata_q <= sense_data_i;
  end

  assign strobe_o = (phase_q == PH_ACT);
  assign relax_o  = (phase_q == PH_PRE) || (phase_q == PH_POST);
  assign done_o   = (phase_q == PH_DONE);
  assign busy_o   = (phase_q != PH_IDLE);
  assign rdata_o  = rdata_q;

endmodule

// File: rtl/fuse_strobe_seq_chk.sv
module fuse_strobe_seq_chk #(
  parameter int TW = 22,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          op_prog_i,
  input logic [TW-1:0] timing_i,
  input logic [DW-1:0] sense_data_i,
  input logic          strobe_o,
  input logic          relax_o,
  input logic          busy_o,
  input logic          done_o,
  input logic [DW-1:0] rdata_o
);

  // R3
  phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe_o, relax_o, done_o}));

  // R9
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_o || relax_o || done_o) |-> busy_o);

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  // R3
  trail_relax_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_o) |-> relax_o);

  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

  // R7
  capture_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata_o) |-> $fell(strobe_o));

endmodule

bind fuse_strobe_seq fuse_strobe_seq_chk #(.TW(TW), .DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .op_prog_i    (op_prog_i),
  .timing_i     (timing_i),
  .sense_data_i (sense_data_i),
  .strobe_o     (strobe_o),
  .relax_o      (relax_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .rdata_o      (rdata_o)
);

// File: tb/fuse_strobe_seq_tb.sv
module fuse_strobe_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  typedef struct packed {
    logic        prog;
    logic [5:0]  rd;
    logic [3:0]  rlx;
    logic [11:0] pg;
    logic [15:0] exp_r;
    logic [15:0] exp_a;
  } vec_t;

  // R2: unselected strobe field carries junk in every vector
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 6'd7,  4'd1,  12'hABC, 16'd2,  16'd4},    // R5
    '{1'b0, 6'd4,  4'd2,  12'hFFF, 16'd3,  16'd1},    // R6 below
    '{1'b0, 6'd6,  4'd2,  12'h001, 16'd3,  16'd1},    // R5 boundary
    '{1'b0, 6'd5,  4'd2,  12'h800, 16'd3,  16'd1},    // R6 equal
    '{1'b1, 6'd63, 4'd3,  12'd20,  16'd4,  16'd13},   // R5 program
    '{1'b1, 6'd40, 4'd0,  12'd0,   16'd1,  16'd1},    // R6 program
    '{1'b0, 6'd63, 4'd15, 12'h123, 16'd16, 16'd32},
    '{1'b1, 6'd0,  4'd15, 12'hFFF, 16'd16, 16'd4064},
    '{1'b0, 6'd0,  4'd0,  12'hFFF, 16'd1,  16'd1},
    '{1'b1, 6'd9,  4'd0,  12'd100, 16'd1,  16'd99}
  };

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        op_prog_i;
  logic [21:0] timing_i;
  logic [31:0] sense_data_i;
  logic        strobe_o;
  logic        relax_o;
  logic        busy_o;
  logic        done_o;
  logic [31:0] rdata_o;

  int n_chk;
  int n_bad;
  logic [31:0] exp_rdata;

  fuse_strobe_seq u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .op_prog_i    (op_prog_i),
    .timing_i     (timing_i),
    .sense_data_i (sense_data_i),
    .strobe_o     (strobe_o),
    .relax_o      (relax_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .rdata_o      (rdata_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_vec(input int idx, input vec_t v);
    int pre_n, act_n, post_n, done_n, busy_n;
    bit first_relax, order_bad;
    int total;
    logic [31:0] base;
    pre_n = 0; act_n = 0; post_n = 0; done_n = 0; busy_n = 0;
    first_relax = 1'b0; order_bad = 1'b0;
    base = 32'hA500_0000 + (32'(idx) << 16);
    @(negedge clk);
    op_prog_i    = v.prog;
    timing_i     = {v.rd, v.rlx, v.pg};
    sense_data_i = base;
    start_i      = 1'b1;
    for (int k = 1; k < 6000; k++) begin
      @(negedge clk);
      if (k == 1) first_relax = relax_o && busy_o;
      if (strobe_o) begin
        act_n++;
        if (post_n != 0 || done_n != 0) order_bad = 1'b1;
      end
      if (relax_o) begin
        if (done_n != 0) order_bad = 1'b1;
        if (act_n == 0) pre_n++; else post_n++;
      end
      if (done_o) begin
        done_n++;
        if (act_n == 0 || post_n == 0) order_bad = 1'b1;
      end
      if (busy_o) busy_n++;
      // R10: disturb timing and operation after the start
      timing_i     = ~{v.rd, v.rlx, v.pg};
      op_prog_i    = ~v.prog;
      sense_data_i = base + 32'(k);
      if (!busy_o) begin
        start_i = 1'b0;
        break;
      end
    end
    total = 2 * int'(v.exp_r) + int'(v.exp_a) + 1;
    chk(first_relax, "R3 leading relax after start", longint'(first_relax), 1);
    chk(!order_bad, "R3 phase order", longint'(order_bad), 0);
    chk(done_n == 1, "R3 done pulse count", done_n, 1);
    chk(pre_n == int'(v.exp_r), "R4/R10 leading relax length", pre_n, v.exp_r);
    chk(post_n == int'(v.exp_r), "R4 trailing relax length", post_n, v.exp_r);
    chk(act_n == int'(v.exp_a), "R5/R6/R2 active length", act_n, v.exp_a);
    chk(busy_n == total, "R9 busy length", busy_n, total);
    if (!v.prog) exp_rdata = base + 32'(v.exp_r) + 32'(v.exp_a);
    chk(rdata_o == exp_rdata, v.prog ? "R8 rdata kept" : "R7 rdata capture",
        rdata_o, exp_rdata);
    @(negedge clk);
    chk(!busy_o, "R9 start in done cycle ignored", busy_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    exp_rdata = '0;
    rst_n = 1'b0;
    start_i = 1'b0;
    op_prog_i = 1'b0;
    timing_i = '0;
    sense_data_i = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!strobe_o && !relax_o && !done_o && !busy_o, "R1 outputs in reset",
        {strobe_o, relax_o, done_o, busy_o}, 0);
    chk(rdata_o == 32'd0, "R1 rdata in reset", rdata_o, 0);
    // R1: start during reset is not taken
    start_i = 1'b1;
    timing_i = 22'h3F_FFFF;
    @(negedge clk);
    chk(!busy_o, "R1 start held in reset", busy_o, 0);
    start_i = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy_o && rdata_o == 32'd0, "R1 idle after release", busy_o, 0);

    for (int i = 0; i < NVEC; i++) run_vec(i, VECS[i]);

    // R8: program directly after a sense capture keeps the captured word
    run_vec(20, '{1'b0, 6'd3, 4'd0, 12'd5, 16'd1, 16'd2});
    run_vec(21, '{1'b1, 6'd3, 4'd1, 12'd9, 16'd2, 16'd6});
    chk(rdata_o == exp_rdata, "R8 rdata after program", rdata_o, exp_rdata);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule